// File: doc/BRIEF.md
# Card Presence Debounce Monitor

This block watches the raw card-presence contact of a card interface. The raw level is synchronised into the engine clock and filtered into a debounced "card present" state. Insertion and removal are filtered at different rates: removal is confirmed quickly, and insertion is confirmed slowly so that a card can settle in its slot. Each confirmed transition sets a sticky event flag. Software clears a flag with a one-cycle clear strobe. The two flags are merged into one interrupt status line.

A polarity input selects which contact level means a card is present, so either edge direction can mark an insertion. Detection runs only while the engine enable is high. When an auto-deactivation enable is set, a confirmed removal also raises a one-cycle request that tells the interface's deactivation sequencer to abort activity and power the card down. The sequencer is a separate block. The synchronised contact level is also brought out for software to read.

Top module: `card_detect_monitor`

## Requirements
- R1: `pin_level` equals the value of `det_pin` two clock edges earlier, because the pin passes through a two-flop synchroniser.
- R2: A present level is accepted as an insertion only when two consecutive samples taken every `BASE_DIV*INS_MULT` clocks both see it. A present level that lasts less than one such period is ignored.
- R3: An absent level is accepted as a removal only when two consecutive samples taken every `BASE_DIV` clocks both see it. An absent level that lasts less than `BASE_DIV` clocks is ignored, while a removal lasting longer than two such periods is accepted even when an insertion of the same length would be rejected.
- R4: With `ins_on_rise`=1 a high contact level means a card is present, so a low-to-high change is an insertion. With `ins_on_rise`=0 a low level means a card is present.
- R5: `ins_flag` and `rem_flag` go high the clock after an accepted insertion or removal. Each stays high until its own clear input (`clr_ins` or `clr_rem`) is high for one clock.
- R6: `det_irq` is high exactly when at least one of `ins_flag` and `rem_flag` is high.
- R7: `deact_req` is a one-cycle pulse raised together with the flag of an accepted removal, but only while `auto_deact_en`=1. When `auto_deact_en`=0 a removal still sets `rem_flag` but gives no pulse.
- R8: While `eng_en`=0 no transition is accepted and the debounced state is held at "no card". Raising `eng_en` with a card already present reports a fresh insertion.
- R9: After reset, `ins_flag`, `rem_flag`, `det_irq`, `deact_req` and `pin_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_pin | input | 1 | Raw card-presence contact, asynchronous |
| eng_en | input | 1 | Engine enable; detection runs only while high |
| ins_on_rise | input | 1 | Polarity: 1 = high level means card present, 0 = low level means card present |
| auto_deact_en | input | 1 | Request deactivation on a confirmed removal |
| clr_ins | input | 1 | Write-one clear strobe for the insertion flag |
| clr_rem | input | 1 | Write-one clear strobe for the removal flag |
| ins_flag | output | 1 | Sticky insertion event |
| rem_flag | output | 1 | Sticky removal event |
| det_irq | output | 1 | Combined card-detect interrupt status |
| pin_level | output | 1 | Synchronised contact level |
| deact_req | output | 1 | One-cycle deactivation request |

## Verification
The bench builds the block with `BASE_DIV`=4 and `INS_MULT`=3, which gives a 4-clock removal period and a 12-clock insertion period. With these periods a glitch shorter than one period, a level held for exactly two periods, and the asymmetry between the two directions can all be reached in a few dozen cycles. A 10-clock level is rejected as an insertion but a 20-clock absence is accepted as a removal. The bench keeps two synchroniser stages and a two-sample agreement, so the delay from a pin change to a flag is at most a few clocks beyond two periods. This lets the checks sample at fixed points that are safely past that delay.

// File: rtl/cd_pkg.sv
package cd_pkg;
  // Debounced card state as held by the filter.
  typedef enum logic {
    CARD_ABSENT  = 1'b0,
    CARD_PRESENT = 1'b1
  } card_state_e;

  // Counter width for a value range of 0..n-1, never below one bit.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cd_tick_gen.sv
module cd_tick_gen #(
  parameter int BASE_DIV = 128,
  parameter int INS_MULT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic rem_tick,
  output logic ins_tick
);
  import cd_pkg::*;
  localparam int BW = cnt_width(BASE_DIV);
  localparam int MW = cnt_width(INS_MULT);
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
  localparam logic [MW-1:0] MULT_LAST = MW'(INS_MULT - 1);

  logic [BW-1:0] base_cnt;
  logic [MW-1:0] mult_cnt;

  assign rem_tick = en && (base_cnt == BASE_LAST);
  assign ins_tick = rem_tick && (mult_cnt == MULT_LAST);

  // Base prescaler: one removal tick per BASE_DIV clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            base_cnt <= '0;
    else if (!en)          base_cnt <= '0;
    else if (rem_tick)     base_cnt <= '0;
    else                   base_cnt <= base_cnt + 1'b1;
  end

  // Second stage: one insertion tick per INS_MULT removal ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mult_cnt <= '0;
    else if (!en)          mult_cnt <= '0;
    else if (ins_tick)     mult_cnt <= '0;
    else if (rem_tick)     mult_cnt <= mult_cnt + 1'b1;
  end
endmodule

// File: rtl/cd_filter.sv
module cd_filter #(
  parameter int AGREE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic raw_present,
  input  logic ins_tick,
  input  logic rem_tick,
  output logic ins_evt,
  output logic rem_evt
);
  import cd_pkg::*;
  localparam int SW = cnt_width(AGREE);
  localparam logic [SW-1:0] STREAK_LAST = SW'(AGREE - 1);

  card_state_e state;
  logic [SW-1:0] streak;
  logic tick, mismatch, flip;

  // The sampling period follows the current state: absent waits for
  // the slow insertion tick, present uses the fast removal tick.
  assign tick     = (state == CARD_PRESENT) ? rem_tick : ins_tick;
  assign mismatch = raw_present != (state == CARD_PRESENT);
  assign flip     = en && tick && mismatch && (streak == STREAK_LAST);
  assign ins_evt  = flip && (state == CARD_ABSENT);
  assign rem_evt  = flip && (state == CARD_PRESENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= CARD_ABSENT;
      streak <= '0;
    end else if (!en) begin
      state  <= CARD_ABSENT;
      streak <= '0;
    end else if (tick) begin
      if (!mismatch) begin
        streak <= '0;
      end else if (flip) begin
        state  <= (state == CARD_PRESENT) ? CARD_ABSENT : CARD_PRESENT;
        streak <= '0;
      end else begin
        streak <= streak + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cd_event_flags.sv
module cd_event_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ins_evt,
  input  logic rem_evt,
  input  logic clr_ins,
  input  logic clr_rem,
  input  logic auto_deact_en,
  output logic ins_flag,
  output logic rem_flag,
  output logic deact_req
);
  // Sticky flags; a new event outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_flag  <= 1'b0;
      rem_flag  <= 1'b0;
      deact_req <= 1'b0;
    end else begin
      if (ins_evt)      ins_flag <= 1'b1;
      else if (clr_ins) ins_flag <= 1'b0;
      if (rem_evt)      rem_flag <= 1'b1;
      else if (clr_rem) rem_flag <= 1'b0;
      deact_req <= rem_evt && auto_deact_en;
    end
  end
endmodule

// File: rtl/card_detect_monitor.sv
module card_detect_monitor #(
  parameter int BASE_DIV    = 128,
  parameter int INS_MULT    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int AGREE       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_pin,
  input  logic eng_en,
  input  logic ins_on_rise,
  input  logic auto_deact_en,
  input  logic clr_ins,
  input  logic clr_rem,
  output logic ins_flag,
  output logic rem_flag,
  output logic det_irq,
  output logic pin_level,
  output logic deact_req
);
  logic pin_s, raw_present, rem_tick, ins_tick, ins_evt, rem_evt;

  cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(det_pin), .q(pin_s)
  );

  assign pin_level   = pin_s;
  assign raw_present = (pin_s == ins_on_rise);

  cd_tick_gen #(.BASE_DIV(BASE_DIV), .INS_MULT(INS_MULT)) u_ticks (
    .clk(clk), .rst_n(rst_n), .en(eng_en),
    .rem_tick(rem_tick), .ins_tick(ins_tick)
  );

  cd_filter #(.AGREE(AGREE)) u_filter (
    .clk(clk), .rst_n(rst_n), .en(eng_en), .raw_present(raw_present),
    .ins_tick(ins_tick), .rem_tick(rem_tick),
    .ins_evt(ins_evt), .rem_evt(rem_evt)
  );

  cd_event_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ins_evt(ins_evt), .rem_evt(rem_evt),
    .clr_ins(clr_ins), .clr_rem(clr_rem), .auto_deact_en(auto_deact_en),
    .ins_flag(ins_flag), .rem_flag(rem_flag), .deact_req(deact_req)
  );

  assign det_irq = ins_flag | rem_flag;
endmodule

// File: rtl/cd_monitor_chk.sv
module cd_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic det_pin,
  input logic pin_level,
  input logic eng_en,
  input logic auto_deact_en,
  input logic clr_ins,
  input logic ins_flag,
  input logic rem_flag,
  input logic det_irq,
  input logic deact_req,
  input logic ins_evt,
  input logic rem_evt
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_pin_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (pin_level == $past(det_pin, 2)));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_flag && !clr_ins) |=> ins_flag);

  assert_flag_follows_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |=> ins_flag);

  assert_irq_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ins_flag) || $rose(rem_flag)) |-> det_irq);

  assert_deact_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |=> !deact_req);

  assert_deact_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |-> ($past(rem_evt) && $past(auto_deact_en)));

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |-> (!ins_evt && !rem_evt));

  assert_evt_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_evt && rem_evt));

  assert_rem_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rem_evt |=> rem_flag);
endmodule

bind card_detect_monitor cd_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .det_pin(det_pin), .pin_level(pin_level),
  .eng_en(eng_en), .auto_deact_en(auto_deact_en), .clr_ins(clr_ins),
  .ins_flag(ins_flag), .rem_flag(rem_flag), .det_irq(det_irq),
  .deact_req(deact_req), .ins_evt(ins_evt), .rem_evt(rem_evt)
);

// File: tb/card_detect_monitor_test.sv
module card_detect_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_pin = 1'b0, eng_en = 1'b0, ins_on_rise = 1'b1, auto_deact_en = 1'b1;
  logic clr_ins = 1'b0, clr_rem = 1'b0;
  logic ins_flag, rem_flag, det_irq, pin_level, deact_req;

  int total = 0;
  int bad = 0;
  int deact_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  card_detect_monitor #(.BASE_DIV(4), .INS_MULT(3), .SYNC_STAGES(2), .AGREE(2)) uut (
    .clk(clk), .rst_n(rst_n), .det_pin(det_pin), .eng_en(eng_en),
    .ins_on_rise(ins_on_rise), .auto_deact_en(auto_deact_en),
    .clr_ins(clr_ins), .clr_rem(clr_rem), .ins_flag(ins_flag),
    .rem_flag(rem_flag), .det_irq(det_irq), .pin_level(pin_level),
    .deact_req(deact_req)
  );

  always @(negedge clk) if (rst_n && deact_req) deact_cnt <= deact_cnt + 1;

  typedef struct packed {
    logic       pin;
    logic [7:0] hold;
    logic       ci;
    logic       cr;
    logic       ei;
    logic       er;
    logic [1:0] dn;
  } vec_t;

  // Polarity: high means present; removal period 4, insertion period 12.
  localparam vec_t VECS [0:8] = '{
    '{1'b0, 8'd40, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // idle absent
    '{1'b1, 8'd8,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R2 short presence ignored
    '{1'b0, 8'd40, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 8'd50, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R2 insertion accepted
    '{1'b1, 8'd20, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0}, // R5 clear
    '{1'b0, 8'd3,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R3 short absence ignored
    '{1'b1, 8'd20, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 8'd20, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1}, // R3 removal, R7 pulse
    '{1'b0, 8'd20, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1}  // R5 clear removal
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic pulse_clear(input bit ci, input bit cr);
    clr_ins = ci; clr_rem = cr;
    step(1);
    clr_ins = 1'b0; clr_rem = 1'b0;
  endtask

  initial begin
    step(3);
    sample();
    chk("R9 ins_flag", ins_flag, 0);
    chk("R9 rem_flag", rem_flag, 0);
    chk("R9 det_irq", det_irq, 0);
    chk("R9 deact_req", deact_req, 0);
    chk("R9 pin_level", pin_level, 0);
    step(1);
    rst_n = 1'b1;
    eng_en = 1'b1;
    step(1);

    for (int i = 0; i < 9; i++) begin
      if (VECS[i].ci || VECS[i].cr) begin
        det_pin = VECS[i].pin;
        pulse_clear(VECS[i].ci, VECS[i].cr);
        step(int'(VECS[i].hold) - 1);
      end else begin
        det_pin = VECS[i].pin;
        step(int'(VECS[i].hold));
      end
      sample();
      chk("R2/R5 ins_flag row", ins_flag, VECS[i].ei);
      chk("R3/R5 rem_flag row", rem_flag, VECS[i].er);
      chk("R6 det_irq row", det_irq, VECS[i].ei | VECS[i].er);
      chk("R7 deact count row", deact_cnt, VECS[i].dn);
      step(0);
    end

    // R3 asymmetry: a 10-clock presence is not an insertion.
    det_pin = 1'b1; step(10); det_pin = 1'b0; step(20);
    sample();
    chk("R3 asymmetric insert reject", ins_flag, 0);

    // R7: removal without auto deactivation.
    auto_deact_en = 1'b0;
    det_pin = 1'b1; step(40);
    pulse_clear(1'b1, 1'b0);
    det_pin = 1'b0; step(20);
    sample();
    chk("R7 rem_flag without auto", rem_flag, 1);
    chk("R7 no extra pulse", deact_cnt, 1);
    pulse_clear(1'b0, 1'b1);

    // R8: no detection while disabled.
    eng_en = 1'b0;
    det_pin = 1'b1; step(40);
    sample();
    chk("R8 disabled no insert", ins_flag, 0);
    det_pin = 1'b0; step(40);
    sample();
    chk("R8 disabled no removal", rem_flag, 0);
    det_pin = 1'b1; step(5);
    eng_en = 1'b1; step(40);
    sample();
    chk("R8 enable with card", ins_flag, 1);
    pulse_clear(1'b1, 1'b0);
    eng_en = 1'b0; step(5);
    eng_en = 1'b1; step(40);
    sample();
    chk("R8 re-enable reports again", ins_flag, 1);
    chk("R8 no removal on disable", rem_flag, 0);

    // R4: low level means present.
    eng_en = 1'b0;
    pulse_clear(1'b1, 1'b1);
    ins_on_rise = 1'b0;
    det_pin = 1'b1; step(5);
    eng_en = 1'b1; step(40);
    sample();
    chk("R4 high is absent", ins_flag, 0);
    det_pin = 1'b0; step(40);
    sample();
    chk("R4 low is insertion", ins_flag, 1);
    det_pin = 1'b1; step(20);
    sample();
    chk("R4 high is removal", rem_flag, 1);

    // R1: two-clock synchroniser delay.
    det_pin = 1'b0; step(5);
    det_pin = 1'b1;
    sample();
    chk("R1 before first edge", pin_level, 0);
    step(1);
    sample();
    chk("R1 after one edge", pin_level, 0);
    step(0);
    @(posedge clk);
    sample();
    chk("R1 after two edges", pin_level, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule